// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog counter that sits on a simple word-wide register bus. Software loads a timeout in units of an external timebase tick, typically 10 ms. It then has to keep writing a 16-bit magic value to a feed register. If the feeds stop, the count runs out, the block drives a system reset pulse and records a timed-out code.

Every control action needs its own 16-bit key: feeding, re-enabling, clearing the status and stopping the timer. A write whose data does not match the key does nothing. Stopping the timer needs a two-step key pair, so a single stray write cannot turn the watchdog off.

A warning interrupt is raised one tick before expiry, with event, mask and force bits. A debug-mode input pauses the countdown unless an override enable bit is set.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is disabled. The disable2 register (0x0C) reads 0xDABE, the timeout register (0x04) reads 6000 (0x1770), the status register (0x10) reads 0x0000, the count (0x14) reads 0, and `irq` and `sys_rst` are low.
- R2: Writing 0xACED to the restart register (0x1C) enables the timer, after which disable2 reads 0x0000. Any other value written there is ignored.
- R3: Writing 0xFEED to the feed register (0x00) while the timer is enabled loads the counter from the timeout register and starts the countdown. Any other value, or a feed while the timer is disabled, has no effect.
- R4: The timer is disabled only when 0x2BAD is written to disable1 (0x08) and the very next bus write is 0xCAFE to disable2 (0x0C). A lone 0xCAFE write, or a key pair with any other write between the two, is ignored. A disabled timer stops counting and holds its count.
- R5: While the countdown is running, each clock cycle with `tick` high lowers the count by one. Bits 14:0 of the count register (0x14) show the count, and without a tick the count holds.
- R6: Bit 15 of the count register reads 1 during a cycle in which the count is about to change on a tick, and reads 0 otherwise.
- R7: The timeout register keeps bits 14:0 of the written data and reads back with bit 15 clear.
- R8: A tick that arrives while the count is 1 or less is an expiry. From the next cycle `sys_rst` is high for exactly 16 cycles, the status register reads 0xCFE8, and the counter reloads from the timeout register and keeps running.
- R9: Writing 0xE8B4 to the status register returns it to 0x0000, and any other value is ignored. An expiry in the same cycle as the clear takes priority.
- R10: The tick that moves the count from 2 to 1 sets the event bit (bit 0 of 0x20). `irq` is the event bit ANDed with mask bit 0 (0x24). Writing data with bit 0 set to 0x20 clears the event.
- R11: While force bit 0 (0x28) is 1, the event bit is held set and acknowledge writes do not clear it.
- R12: Bit 1 of the override register (0x18) reflects the `dbg_mode` input and bit 0 is a writable watchdog enable. While `dbg_mode` is high and bit 0 is 0, ticks do not change the count and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one cycle per count unit |
| dbg_mode | input | 1 | High while a debugger holds the chip |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Pre-timeout interrupt |
| sys_rst | output | 1 | System reset pulse on expiry |

## Verification
The hardest case to reach is the key pair with another bus write between its two halves. Most benches only ever issue the two halves back to back, so the cancellation path is never tested. The stimulus places a timeout-register write between 0x2BAD and 0xCAFE and checks that disable2 still reads the enabled code. It then issues the pair back to back. Expiry is reached quickly by programming a timeout of 5 and driving single-cycle ticks by hand. This puts the 2-to-1 warning tick, the expiry tick and the 16-cycle reset pulse within a few dozen cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 15;

  localparam logic [ADDR_W-1:0] A_FEED  = 6'h00;
  localparam logic [ADDR_W-1:0] A_TOUT  = 6'h04;
  localparam logic [ADDR_W-1:0] A_DIS1  = 6'h08;
  localparam logic [ADDR_W-1:0] A_DIS2  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_STAT  = 6'h10;
  localparam logic [ADDR_W-1:0] A_COUNT = 6'h14;
  localparam logic [ADDR_W-1:0] A_OVR   = 6'h18;
  localparam logic [ADDR_W-1:0] A_RSTRT = 6'h1C;
  localparam logic [ADDR_W-1:0] A_EVT   = 6'h20;
  localparam logic [ADDR_W-1:0] A_MASK  = 6'h24;
  localparam logic [ADDR_W-1:0] A_FORCE = 6'h28;

  localparam logic [DATA_W-1:0] K_FEED  = 16'hFEED;
  localparam logic [DATA_W-1:0] K_DIS1  = 16'h2BAD;
  localparam logic [DATA_W-1:0] K_DIS2  = 16'hCAFE;
  localparam logic [DATA_W-1:0] K_RSTRT = 16'hACED;
  localparam logic [DATA_W-1:0] K_CLR   = 16'hE8B4;

  localparam logic [DATA_W-1:0] C_OFF   = 16'hDABE;
  localparam logic [DATA_W-1:0] C_TOUT  = 16'hCFE8;
endpackage

// File: rtl/wdt_keyctl.sv
module wdt_keyctl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              enabled,
  output logic              feed_ok,
  output logic              clr_ok
);
  logic arm_q, arm_d, en_q, en_d;
  logic hit_rstrt, hit_dis2;

  assign hit_rstrt = wr_en && addr == A_RSTRT && wdata == K_RSTRT;
  assign hit_dis2  = wr_en && addr == A_DIS2 && wdata == K_DIS2;

  always_comb begin
    arm_d = arm_q;
    en_d  = en_q;
    if (wr_en) arm_d = (addr == A_DIS1) && (wdata == K_DIS1);
    if (hit_rstrt) en_d = 1'b1;
    else if (hit_dis2 && arm_q) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      arm_q <= arm_d;
      en_q  <= en_d;
    end
  end

  assign enabled = en_q;
  assign feed_ok = en_q && wr_en && addr == A_FEED && wdata == K_FEED;
  assign clr_ok  = wr_en && addr == A_STAT && wdata == K_CLR;

  // R4: the timer can only turn off right after a disable2 key write
  assert_disable_keyed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(wr_en && addr == A_DIS2 && wdata == K_DIS2));
  // R2: the timer can only turn on after a restart key write
  assert_enable_keyed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(wr_en && addr == A_RSTRT && wdata == K_RSTRT));
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enabled,
  input  logic             gate_ok,
  input  logic             feed,
  input  logic [CNT_W-1:0] timeout,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             warn,
  output logic             expire
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign step   = tick && run_q && enabled && gate_ok;
  assign expire = step && (cnt_q <= CNT_W'(1));
  assign warn   = step && (cnt_q == CNT_W'(2));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!enabled) run_d = 1'b0;
    else if (feed) run_d = 1'b1;
    if (feed || expire) cnt_d = timeout;
    else if (step) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R5: the count holds unless a tick or a feed arrives
  assert_count_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !feed) |=> $stable(cnt_q));
  // R8: an expiry reloads the counter from the timeout register
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !feed) |=> cnt_q == $past(timeout));
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit,
  input  logic              warn,
  output logic              evt,
  output logic              mask,
  output logic              force_on,
  output logic              irq
);
  logic evt_q, evt_d, mask_q, mask_d, frc_q, frc_d;

  always_comb begin
    evt_d  = evt_q;
    mask_d = mask_q;
    frc_d  = frc_q;
    if (wr_en && addr == A_MASK)  mask_d = wbit;
    if (wr_en && addr == A_FORCE) frc_d  = wbit;
    if (warn || frc_q) evt_d = 1'b1;
    else if (wr_en && addr == A_EVT && wbit) evt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      mask_q <= 1'b0;
      frc_q  <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      mask_q <= mask_d;
      frc_q  <= frc_d;
    end
  end

  assign evt      = evt_q;
  assign mask     = mask_q;
  assign force_on = frc_q;
  assign irq      = evt_q && mask_q;

  // R10: the warning tick sets the event bit
  assert_warn_sets_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    warn |=> evt_q);
  // R11: force keeps the event bit set
  assert_force_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frc_q |=> evt_q);
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic sys_rst
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  logic [RW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (expire) left_d = RW'(RST_CYCLES);
    else if (left_q != '0) left_d = left_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign sys_rst = (left_q != '0);

  // R8: an expiry raises the reset output in the next cycle
  assert_rst_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sys_rst);
  // R8: the reset pulse only starts after an expiry
  assert_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(expire));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_INIT = 6000,
  parameter int RST_CYCLES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbg_mode,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst
);
  localparam int PAD = DATA_W - CNT_W;

  logic             enabled, feed_ok, clr_ok;
  logic [CNT_W-1:0] tout_q, tout_d, cnt;
  logic             stat_q, stat_d, ovr_q, ovr_d;
  logic             step, warn, expire;
  logic             evt, mask, force_on;

  wdt_keyctl u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .enabled(enabled), .feed_ok(feed_ok), .clr_ok(clr_ok)
  );

  wdt_count u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enabled(enabled),
    .gate_ok(!dbg_mode || ovr_q), .feed(feed_ok), .timeout(tout_q),
    .cnt(cnt), .step(step), .warn(warn), .expire(expire)
  );

  wdt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wbit(bus_wdata[0]),
    .warn(warn), .evt(evt), .mask(mask), .force_on(force_on), .irq(irq)
  );

  wdt_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .expire(expire), .sys_rst(sys_rst)
  );

  always_comb begin
    tout_d = tout_q;
    ovr_d  = ovr_q;
    stat_d = stat_q;
    if (bus_wr && bus_addr == A_TOUT) tout_d = bus_wdata[CNT_W-1:0];
    if (bus_wr && bus_addr == A_OVR)  ovr_d  = bus_wdata[0];
    if (expire) stat_d = 1'b1;
    else if (clr_ok) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_q <= CNT_W'(TIMEOUT_INIT);
      ovr_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      tout_q <= tout_d;
      ovr_q  <= ovr_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TOUT:  bus_rdata = {{PAD{1'b0}}, tout_q};
      A_DIS2:  bus_rdata = enabled ? '0 : C_OFF;
      A_STAT:  bus_rdata = stat_q ? C_TOUT : '0;
      A_COUNT: bus_rdata = {step, cnt};
      A_OVR:   bus_rdata = {{(DATA_W-2){1'b0}}, dbg_mode, ovr_q};
      A_EVT:   bus_rdata = {{(DATA_W-1){1'b0}}, evt};
      A_MASK:  bus_rdata = {{(DATA_W-1){1'b0}}, mask};
      A_FORCE: bus_rdata = {{(DATA_W-1){1'b0}}, force_on};
      default: bus_rdata = '0;
    endcase
  end

  // R8: an expiry latches the timed-out status
  assert_status_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q);
  // R9: the status only clears on the clear key
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> $past(bus_wr && bus_addr == A_STAT && bus_wdata == K_CLR));
  // R12: a paused countdown never expires
  assert_debug_pause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !ovr_q) |-> !expire);
endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  logic        clk, rst_n, tick, dbg_mode, bus_wr, irq, sys_rst;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  int checks, errors;
  bit done;

  keyed_wdt dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_mode(dbg_mode), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst(sys_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // one tick pulse; returns the count register seen while tick is high
  task automatic pulse(output logic [15:0] during);
    @(negedge clk);
    tick = 1'b1; bus_addr = 6'h14;
    #1 during = bus_rdata;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(6'h0C, v); chk("R1 disable2", v, 16'hDABE);
    rd(6'h04, v); chk("R1 timeout", v, 16'h1770);
    rd(6'h10, v); chk("R1 status", v, 16'h0000);
    rd(6'h14, v); chk("R1 count", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 sys_rst", {15'd0, sys_rst}, 16'd0);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    wr(6'h04, 16'h0005);
    wr(6'h00, 16'hFEED);
    rd(6'h14, v); chk("R3 feed while disabled", v, 16'h0000);
    wr(6'h1C, 16'h1234);
    rd(6'h0C, v); chk("R2 wrong restart key", v, 16'hDABE);
    wr(6'h1C, 16'hACED);
    rd(6'h0C, v); chk("R2 restart key", v, 16'h0000);
    wr(6'h00, 16'hFEEC);
    rd(6'h14, v); chk("R3 wrong feed key", v, 16'h0000);
    wr(6'h00, 16'hFEED);
    rd(6'h14, v); chk("R3 feed loads", v, 16'h0005);
  endtask

  task automatic t_count();
    logic [15:0] v, d;
    pulse(d);
    chk("R6 busy bit during tick", d, 16'h8005);
    rd(6'h14, v); chk("R5 decrement", v, 16'h0004);
    repeat (5) @(negedge clk);
    rd(6'h14, v); chk("R5 hold without tick", v, 16'h0004);
  endtask

  task automatic t_warn_expire();
    logic [15:0] v, d;
    int n;
    wr(6'h24, 16'h0001);
    pulse(d); pulse(d);
    rd(6'h20, v); chk("R10 no early event", v, 16'h0000);
    pulse(d);
    rd(6'h20, v); chk("R10 event at 2->1", v, 16'h0001);
    chk("R10 irq", {15'd0, irq}, 16'd1);
    wr(6'h20, 16'h0001);
    rd(6'h20, v); chk("R10 ack", v, 16'h0000);
    chk("R10 irq after ack", {15'd0, irq}, 16'd0);
    pulse(d);
    n = 0;
    while (sys_rst && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R8 reset width", 16'(n), 16'd16);
    rd(6'h10, v); chk("R8 status", v, 16'hCFE8);
    rd(6'h14, v); chk("R8 reload", v, 16'h0005);
  endtask

  task automatic t_status();
    logic [15:0] v;
    wr(6'h10, 16'h1234);
    rd(6'h10, v); chk("R9 wrong clear key", v, 16'hCFE8);
    wr(6'h10, 16'hE8B4);
    rd(6'h10, v); chk("R9 clear", v, 16'h0000);
  endtask

  task automatic t_force();
    logic [15:0] v;
    wr(6'h28, 16'h0001);
    rd(6'h20, v); chk("R11 force sets", v, 16'h0001);
    wr(6'h20, 16'h0001);
    rd(6'h20, v); chk("R11 ack blocked", v, 16'h0001);
    wr(6'h28, 16'h0000);
    wr(6'h20, 16'h0001);
    rd(6'h20, v); chk("R11 ack after release", v, 16'h0000);
  endtask

  task automatic t_debug();
    logic [15:0] v, d;
    @(negedge clk); dbg_mode = 1'b1;
    rd(6'h18, v); chk("R12 mode bit", v, 16'h0002);
    pulse(d);
    rd(6'h14, v); chk("R12 paused", v, 16'h0005);
    wr(6'h18, 16'h0001);
    pulse(d);
    rd(6'h14, v); chk("R12 override counts", v, 16'h0004);
    wr(6'h18, 16'h0000);
    @(negedge clk); dbg_mode = 1'b0;
  endtask

  task automatic t_disable();
    logic [15:0] v, d;
    wr(6'h08, 16'h2BAD);
    wr(6'h04, 16'h0005);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R4 broken pair ignored", v, 16'h0000);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R4 lone key2 ignored", v, 16'h0000);
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R4 pair disables", v, 16'hDABE);
    pulse(d);
    rd(6'h14, v); chk("R4 count held", v, 16'h0004);
  endtask

  task automatic t_width();
    logic [15:0] v;
    wr(6'h04, 16'hFFFF);
    rd(6'h04, v); chk("R7 timeout width", v, 16'h7FFF);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0; dbg_mode = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_count();
    t_warn_expire();
    t_status();
    t_force();
    t_debug();
    t_disable();
    t_width();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule